// File: doc/BRIEF.md
# Fast UART Interrupt and Control Register Bank

This block is the software-visible control and interrupt logic for a fast serial port. A simple word bus writes a control word and an 8-bit rate divisor. The control word carries the interrupt enables, the FIFO thresholds, the forced-break bit, the sampling offset, the receive timeout and the CTS/RTS flow-control settings. The block presents both values as outputs to the transmit, receive and baud-generation logic that sits next to it.

The neighbouring paths report events to the block. Transmit-below-threshold, framing error, break and overrun arrive as one-cycle pulses. The block latches each of them in an interrupt status register, and software clears a latched bit by writing a one to it. Receive-trigger and receive-timeout are level conditions, and the status register shows their live state. Each status source is ANDed with one of three enables (transmit, receive, error), and the results are ORed into a single interrupt line.

Software can also read the transmit and receive FIFO fill levels through the bank. The asynchronous reset is released through a two-stage synchronizer.

Top module: `uart_irq_bank`

## Requirements
- R1: While reset is held and after its release, the control word reads 0, the rate reads 0xFF, the status register reads 0 with the live inputs low, and `irq` is 0.
- R2: A write to offset 0x0C stores bits 21:0 as the control word and drives them on `ctrl_word`. Bits 31:22 read as 0.
- R3: A write to offset 0x10 stores bits 7:0 as the rate divisor. Bits 31:8 read as 0.
- R4: Status bits are latched at these positions: bit 0 transmit, bit 3 framing error, bit 4 break, bit 5 overrun. A pulse on the matching event input sets the bit, and it stays set until software clears it.
- R5: Writing to offset 0x08 clears each latched bit written as 1 and leaves the bits written as 0 unchanged.
- R6: When an event pulse and a clear of its bit fall in the same cycle, the bit stays set.
- R7: Status bit 1 follows `rx_trig_live` and status bit 2 follows `rx_tmo_live`. Writes to those bits have no effect.
- R8: Writing 1 to status bit 6 sets the latched transmit bit (bit 0). Bit 6 always reads as 0.
- R9: `irq` is high when any of these holds: the transmit bit is set and control bit 5 is set; either receive live bit is high and control bit 6 is set; or framing error, break or overrun is set and control bit 7 is set.
- R10: A read of offset 0x04 returns the transmit level in bits 15:8 and the receive level in bits 7:0.
- R11: A write to offset 0x00 or to any unmapped offset changes no register. Those offsets read as 0.
- R12: Event pulses set their latched bits whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_tx_low | input | 1 | Transmit FIFO below threshold pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_break | input | 1 | Break received pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| rx_trig_live | input | 1 | Receive FIFO at trigger level |
| rx_tmo_live | input | 1 | Receive inactivity timeout active |
| tx_level | input | 8 | Transmit FIFO fill level |
| rx_level | input | 8 | Receive FIFO fill level |
| ctrl_word | output | 22 | Current control word |
| rate_div | output | 8 | Current rate divisor |
| irq | output | 1 | Combined interrupt |

## Verification
The bench pulses an event in the same cycle as a write-one clear of its bit. A design in which the clear wins would lose that event, and the status register would read back 0. Writes with mixed ones and zeros show whether a design clears bits it was not asked to clear. Writes to the live receive bits show whether a design wrongly latches them. The bench walks each enable with sources both inside and outside its group. A design with swapped enable groups would raise `irq` for the wrong sources, or would fail to raise it for the right ones.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  // register offsets (bytes)
  localparam int unsigned OFS_FIFO  = 0;
  localparam int unsigned OFS_LEVEL = 4;
  localparam int unsigned OFS_STAT  = 8;
  localparam int unsigned OFS_CTRL  = 12;
  localparam int unsigned OFS_RATE  = 16;

  // status bit positions
  localparam int unsigned SB_TX     = 0;
  localparam int unsigned SB_RXTRIG = 1;
  localparam int unsigned SB_RXTMO  = 2;
  localparam int unsigned SB_FE     = 3;
  localparam int unsigned SB_BRK    = 4;
  localparam int unsigned SB_OE     = 5;
  localparam int unsigned SB_TXSET  = 6;

  // control enable positions
  localparam int unsigned CB_TXEN  = 5;
  localparam int unsigned CB_RXEN  = 6;
  localparam int unsigned CB_ERREN = 7;
  localparam int unsigned CTRL_W   = 22;

  // latched source order inside the latch bank
  localparam int unsigned LI_TX  = 0;
  localparam int unsigned LI_FE  = 1;
  localparam int unsigned LI_BRK = 2;
  localparam int unsigned LI_OE  = 3;
  localparam int unsigned LATCH_N = 4;
endpackage

// File: rtl/uirq_cfg_regs.sv
module uirq_cfg_regs #(
  parameter int unsigned CW        = 22,
  parameter int unsigned RW        = 8,
  parameter logic [RW-1:0] RATE_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          rate_we,
  input  logic [CW-1:0] ctrl_wd,
  input  logic [RW-1:0] rate_wd,
  output logic [CW-1:0] ctrl_q,
  output logic [RW-1:0] rate_q
);
  logic [CW-1:0] ctrl_d;
  logic [RW-1:0] rate_d;

  always_comb begin
    ctrl_d = ctrl_q;
    rate_d = rate_q;
    if (ctrl_we) ctrl_d = ctrl_wd;
    if (rate_we) rate_d = rate_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
    end else begin
      ctrl_q <= ctrl_d;
      rate_q <= rate_d;
    end
  end

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
  a_r3_rate_load: assert property (@(posedge clk) disable iff (!rst_n)
    rate_we |=> rate_q == $past(rate_wd));
endmodule

// File: rtl/uirq_latch_bank.sv
module uirq_latch_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_q
);
  logic [N-1:0] lat_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // a new event outranks a clear in the same cycle
    always_comb begin
      lat_d[i] = lat_q[i];
      if (clr_i[i]) lat_d[i] = 1'b0;
      if (set_i[i]) lat_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= 1'b0;
      else        lat_q[i] <= lat_d[i];
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> lat_q[i]);
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[i] && !clr_i[i]) |=> lat_q[i]);
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !lat_q[i]);
  end
endmodule

// File: rtl/uirq_gate.sv
module uirq_gate
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LATCH_N-1:0] lat,
  input  logic               rx_trig,
  input  logic               rx_tmo,
  input  logic               en_tx,
  input  logic               en_rx,
  input  logic               en_err,
  output logic               irq
);
  logic tx_hit, rx_hit, err_hit;

  always_comb begin
    tx_hit  = en_tx  & lat[LI_TX];
    rx_hit  = en_rx  & (rx_trig | rx_tmo);
    err_hit = en_err & (lat[LI_FE] | lat[LI_BRK] | lat[LI_OE]);
    irq     = tx_hit | rx_hit | err_hit;
  end

  a_r9_err_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (en_err && lat[LI_BRK]) |-> irq);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_tx && !en_rx && !en_err) |-> !irq);
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import uirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_tx_low,
  input  logic              ev_frame,
  input  logic              ev_break,
  input  logic              ev_overrun,
  input  logic              rx_trig_live,
  input  logic              rx_tmo_live,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [RATE_W-1:0] rate_div,
  output logic              irq
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               ctrl_we, rate_we, stat_we;
  logic [LATCH_N-1:0] lat_set, lat_clr, lat_q;
  logic               unused_wdata_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    ctrl_we = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    rate_we = bus_wr && (bus_addr == ADDR_W'(OFS_RATE));
    stat_we = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  end

  always_comb begin
    lat_set         = '0;
    lat_set[LI_TX]  = ev_tx_low | (stat_we & bus_wdata[SB_TXSET]);
    lat_set[LI_FE]  = ev_frame;
    lat_set[LI_BRK] = ev_break;
    lat_set[LI_OE]  = ev_overrun;
    lat_clr         = '0;
    if (stat_we) begin
      lat_clr[LI_TX]  = bus_wdata[SB_TX];
      lat_clr[LI_FE]  = bus_wdata[SB_FE];
      lat_clr[LI_BRK] = bus_wdata[SB_BRK];
      lat_clr[LI_OE]  = bus_wdata[SB_OE];
    end
  end

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTRL_W];

  uirq_cfg_regs #(
    .CW(CTRL_W), .RW(RATE_W), .RATE_RST({RATE_W{1'b1}})
  ) i_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctrl_we (ctrl_we),
    .rate_we (rate_we),
    .ctrl_wd (bus_wdata[CTRL_W-1:0]),
    .rate_wd (bus_wdata[RATE_W-1:0]),
    .ctrl_q  (ctrl_word),
    .rate_q  (rate_div)
  );

  uirq_latch_bank #(.N(LATCH_N)) i_lat (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (lat_set),
    .clr_i (lat_clr),
    .lat_q (lat_q)
  );

  uirq_gate i_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lat     (lat_q),
    .rx_trig (rx_trig_live),
    .rx_tmo  (rx_tmo_live),
    .en_tx   (ctrl_word[CB_TXEN]),
    .en_rx   (ctrl_word[CB_RXEN]),
    .en_err  (ctrl_word[CB_ERREN]),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_LEVEL): begin
        bus_rdata[LVL_W-1:0]       = rx_level;
        bus_rdata[2*LVL_W-1:LVL_W] = tx_level;
      end
      ADDR_W'(OFS_STAT): begin
        bus_rdata[SB_TX]     = lat_q[LI_TX];
        bus_rdata[SB_RXTRIG] = rx_trig_live;
        bus_rdata[SB_RXTMO]  = rx_tmo_live;
        bus_rdata[SB_FE]     = lat_q[LI_FE];
        bus_rdata[SB_BRK]    = lat_q[LI_BRK];
        bus_rdata[SB_OE]     = lat_q[LI_OE];
      end
      ADDR_W'(OFS_CTRL): bus_rdata[CTRL_W-1:0] = ctrl_word;
      ADDR_W'(OFS_RATE): bus_rdata[RATE_W-1:0] = rate_div;
      default:           bus_rdata = '0;
    endcase
  end

  a_r11_fifo_wr_inert: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_FIFO)) |=> ($stable(ctrl_word) && $stable(rate_div)));
  a_r8_txset: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_we && bus_wdata[SB_TXSET]) |=> lat_q[LI_TX]);
endmodule

// File: tb/test_uart_irq_bank.sv
module test_uart_irq_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ev_tx_low, ev_frame, ev_break, ev_overrun;
  logic        rx_trig_live, rx_tmo_live;
  logic [7:0]  tx_level, rx_level;
  logic [21:0] ctrl_word;
  logic [7:0]  rate_div;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_bank i_uart_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_tx_low(ev_tx_low),
    .ev_frame(ev_frame), .ev_break(ev_break), .ev_overrun(ev_overrun),
    .rx_trig_live(rx_trig_live), .rx_tmo_live(rx_tmo_live),
    .tx_level(tx_level), .rx_level(rx_level), .ctrl_word(ctrl_word),
    .rate_div(rate_div), .irq(irq)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  // one bus cycle; evm = {overrun, break, frame, tx} pulses for that cycle
  task automatic cyc(input bit wr, input logic [4:0] a, input logic [31:0] d,
                     input logic [3:0] evm);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    {ev_overrun, ev_break, ev_frame, ev_tx_low} = evm;
    @(posedge clk); #1;
    bus_wr = 1'b0; {ev_overrun, ev_break, ev_frame, ev_tx_low} = 4'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 4'b0);
  endtask

  task automatic pulse(input logic [3:0] evm);
    cyc(1'b0, 5'h1f, 32'h0, evm);
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input bit exp, input string req);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {31'd0, exp}; it.req = req;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ev_tx_low = 0; ev_frame = 0; ev_break = 0; ev_overrun = 0;
    rx_trig_live = 0; rx_tmo_live = 0; tx_level = '0; rx_level = '0;

    // R1 while held in reset
    chk_rd(5'h0C, 32'h0, "R1 ctrl in reset");
    chk_rd(5'h10, 32'hFF, "R1 rate in reset");
    chk_rd(5'h08, 32'h0, "R1 status in reset");
    chk_irq(1'b0, "R1 irq in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    chk_rd(5'h10, 32'hFF, "R1 rate after release");

    // R2 control word
    wr(5'h0C, 32'hFFFF_FFFF);
    chk_rd(5'h0C, 32'h003F_FFFF, "R2 ctrl all ones");
    wr(5'h0C, 32'h0012_A51C);
    chk_rd(5'h0C, 32'h0012_A51C, "R2 ctrl pattern");
    wr(5'h0C, 32'h0);

    // R3 rate
    wr(5'h10, 32'h0000_1234);
    chk_rd(5'h10, 32'h34, "R3 rate low byte");

    // R4 / R12 latching with enables off
    pulse(4'b0010);
    chk_rd(5'h08, 32'h08, "R4 frame latched");
    chk_irq(1'b0, "R12 no irq without enable");
    pulse(4'b1101);
    chk_rd(5'h08, 32'h39, "R12 all latched sources set");

    // R5 selective clear
    wr(5'h08, 32'h08);
    chk_rd(5'h08, 32'h31, "R5 only frame cleared");

    // R6 set beats clear
    cyc(1'b1, 5'h08, 32'h31, 4'b1000);
    chk_rd(5'h08, 32'h20, "R6 overrun survives clear");
    wr(5'h08, 32'h20);
    chk_rd(5'h08, 32'h00, "R5 overrun cleared");

    // R7 live receive bits
    rx_trig_live = 1'b1;
    chk_rd(5'h08, 32'h02, "R7 trig live");
    wr(5'h08, 32'h06);
    chk_rd(5'h08, 32'h02, "R7 write ignored");
    rx_tmo_live = 1'b1;
    chk_rd(5'h08, 32'h06, "R7 timeout live");
    rx_trig_live = 1'b0; rx_tmo_live = 1'b0;

    // R8 software set
    wr(5'h08, 32'h40);
    chk_rd(5'h08, 32'h01, "R8 tx set via bit 6");

    // R9 enable groups
    wr(5'h0C, 32'h20);
    chk_irq(1'b1, "R9 tx enable");
    wr(5'h0C, 32'h40);
    chk_irq(1'b0, "R9 rx enable ignores tx");
    rx_trig_live = 1'b1;
    chk_irq(1'b1, "R9 rx trig");
    rx_trig_live = 1'b0;
    rx_tmo_live = 1'b1;
    chk_irq(1'b1, "R9 rx timeout");
    rx_tmo_live = 1'b0;
    wr(5'h08, 32'h01);
    wr(5'h0C, 32'h80);
    chk_irq(1'b0, "R9 err enable idle");
    pulse(4'b0100);
    chk_irq(1'b1, "R9 break via err enable");
    wr(5'h08, 32'h10);
    chk_irq(1'b0, "R9 cleared break drops irq");

    // R10 level
    tx_level = 8'h37; rx_level = 8'h5A;
    chk_rd(5'h04, 32'h0000_375A, "R10 levels");

    // R11 fifo and unmapped offsets
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    chk_rd(5'h0C, 32'h80, "R11 ctrl untouched");
    chk_rd(5'h10, 32'h34, "R11 rate untouched");
    chk_rd(5'h00, 32'h0, "R11 fifo offset reads 0");
    chk_rd(5'h14, 32'h0, "R11 unmapped reads 0");

    repeat (2) @(posedge clk);
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule